// File: doc/BRIEF.md
# SPI Burst Master with Discard Phase

This block is an SPI master that runs one chip-select burst per start command. Software fills a transmit byte queue with a command and its address, writes the total number of bytes in the burst and the number of bytes to take from the queue, then sets the start bit. The engine drives the serial clock and the output data line, and samples the input data line. It pulls chip select low for the whole burst.

The burst has two phases, split by a byte counter. In the transmit phase, bytes come from the transmit queue and whatever returns on the input line is thrown away. In the receive phase, the engine clocks out filler bytes of 0x00 and pushes every received byte into the receive queue. A read command with a 1-byte opcode therefore leaves only the reply bytes in the receive queue. A burst whose transmit count covers the whole burst, such as a command followed by an address, leaves nothing there.

The engine is a four-state machine. From `ST_IDLE`, a start with a nonzero total moves it to `ST_SHIFT_LO` and loads the first byte. `ST_SHIFT_LO` moves to `ST_SHIFT_HI` after half an SCLK period, at the rising edge. `ST_SHIFT_HI` returns to `ST_SHIFT_LO` at each falling edge. After the eighth bit of the last byte it goes to `ST_TRAIL` instead. `ST_TRAIL` holds chip select low for half a period and then returns to `ST_IDLE`.

Top module: `spi_burst_master`

## Requirements
- R1: The block is always the master. `spi_cs_n` is low for exactly one span per burst and high whenever the engine is idle. `spi_sclk` is low whenever `spi_cs_n` is high, and is low at the moment `spi_cs_n` falls.
- R2: Writing bit 31 = 1 to the control word (word 0, byte offset 0x00) starts a burst if the engine is idle and the total length is nonzero. Bit 31 of the control word reads back 1 while the burst runs and 0 after it ends. A start written while a burst is running has no effect on that burst.
- R3: The total length (word 2, offset 0x08) and the transmit count (word 3, offset 0x0C) are separate registers, and the engine latches both at start. A burst produces exactly 8 × total rising SCLK edges. It takes exactly min(transmit count, total) bytes from the transmit queue, and any extra bytes stay queued.
- R4: Bytes received while the first min(transmit count, total) bytes are sent are dropped. Every later byte is pushed to the receive queue in order. Examples: total 5 with count 1 leaves 4 bytes, total 13 with count 1 leaves 12, and total 4 with count 4 leaves 0.
- R5: After the transmit count is used up, or when the transmit queue is empty, the output line carries the filler byte 0x00.
- R6: The bus runs in SPI mode 0, MSB first. `spi_mosi` changes only while SCLK is low. `spi_miso` is sampled on each rising SCLK edge.
- R7: The SCLK period is CLK_DIV system clocks. The first rising edge comes CLK_DIV/2 clocks after `spi_cs_n` falls. `spi_cs_n` rises CLK_DIV/2 clocks after the last falling edge.
- R8: Writing the queue-control word (word 1, offset 0x04) with bit 31 set empties the transmit queue, and with bit 15 set empties the receive queue. Each bit clears itself one cycle later.
- R9: Each queue holds FIFO_DEPTH (64) bytes. Writes to the transmit data word (word 4, offset 0x10, bits 7:0) are ignored while that queue is full. Reading the receive data word (word 5, offset 0x14, bits 7:0) removes one byte, and returns 0 when the queue is empty. A received byte that finds the receive queue full is dropped.
- R10: The level word (word 6, offset 0x18) shows the transmit queue level in bits 6:0 and the receive queue level in bits 22:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check several rules on every cycle:
- the output data line stays steady while SCLK is high;
- chip select falls only while SCLK is low;
- a queue pop and a receive push never happen in the same cycle;
- a start always raises busy;
- the queue-control bits clear themselves;
- neither queue goes past its depth.

Other behaviour only the bench scenarios can show. These are the split between discarded and kept bytes for every pairing of total and transmit count, the filler bytes, the edge counts, and the half-period spacing around chip select. The bench checks them by replaying bursts against a serial model that returns a computed byte pattern.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SHIFT_LO = 2'd1,
        ST_SHIFT_HI = 2'd2,
        ST_TRAIL    = 2'd3
    } eng_state_t;

    localparam logic [2:0] W_CTRL  = 3'd0;
    localparam logic [2:0] W_QCTL  = 3'd1;
    localparam logic [2:0] W_TOTAL = 3'd2;
    localparam logic [2:0] W_TXCNT = 3'd3;
    localparam logic [2:0] W_TXDAT = 3'd4;
    localparam logic [2:0] W_RXDAT = 3'd5;
    localparam logic [2:0] W_LEVEL = 3'd6;

    localparam logic [7:0] FILL_BYTE = 8'h00;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic             do_push;
    logic             do_pop;

    always_comb begin
        level   = wr_ptr - rd_ptr;
        full    = (level == (AW+1)'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        dout    = empty ? '0 : mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= din;
    end

    // R9: the level never exceeds the depth
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));

    // R9: a push into a full queue leaves it full and unchanged
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] total_len,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    eng_state_t       state;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [LEN_W-1:0] byte_idx;
    logic [LEN_W-1:0] total_q;
    logic [LEN_W-1:0] txcnt_q;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    logic             half_done;
    logic             launch;
    logic             byte_end;
    logic             last_byte;
    logic             first_take;
    logic             next_take;
    logic [7:0]       first_byte;
    logic [7:0]       next_byte;

    always_comb begin
        half_done  = (div_cnt == DIV_W'(HALF - 1));
        launch     = (state == ST_IDLE) && go && (total_len != '0);
        byte_end   = (state == ST_SHIFT_HI) && half_done && (bit_cnt == 3'd7);
        last_byte  = ((byte_idx + LEN_W'(1)) == total_q);
        first_take = (tx_len != '0) && !tx_empty;
        next_take  = ((byte_idx + LEN_W'(1)) < txcnt_q) && !tx_empty;
        first_byte = first_take ? tx_head : FILL_BYTE;
        next_byte  = next_take  ? tx_head : FILL_BYTE;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            total_q  <= '0;
            txcnt_q  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    div_cnt <= '0;
                    if (launch) begin
                        state    <= ST_SHIFT_LO;
                        total_q  <= total_len;
                        txcnt_q  <= tx_len;
                        byte_idx <= '0;
                        bit_cnt  <= '0;
                        tx_sh    <= first_byte;
                    end
                end
                ST_SHIFT_LO: begin
                    if (half_done) begin
                        state   <= ST_SHIFT_HI;
                        div_cnt <= '0;
                        rx_sh   <= {rx_sh[6:0], miso};
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_SHIFT_HI: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        if (bit_cnt == 3'd7) begin
                            bit_cnt <= '0;
                            if (last_byte) begin
                                state <= ST_TRAIL;
                            end else begin
                                state    <= ST_SHIFT_LO;
                                byte_idx <= byte_idx + 1'b1;
                                tx_sh    <= next_byte;
                            end
                        end else begin
                            state   <= ST_SHIFT_LO;
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (half_done) begin
                        state   <= ST_IDLE;
                        div_cnt <= '0;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        cs_n    = (state == ST_IDLE);
        sclk    = (state == ST_SHIFT_HI);
        mosi    = tx_sh[7];
        rx_byte = rx_sh;
        tx_pop  = (launch && first_take) || (byte_end && !last_byte && next_take);
        rx_push = byte_end && (byte_idx >= txcnt_q);
    end

    // R6: data out holds steady through every high SCLK phase
    p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R1: chip select only falls with SCLK low
    p_cs_fall_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);

    // R4: a transmit-phase pop never coincides with a receive push
    p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !rx_push);

    // R2: an accepted start makes the engine busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !cs_n));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    logic [2:0]       word;
    logic             wr_en;
    logic             rd_en;
    logic [LEN_W-1:0] total_r;
    logic [LEN_W-1:0] txcnt_r;
    logic             flush_tx_q;
    logic             flush_rx_q;

    logic             busy;
    logic             go;
    logic             tx_pop;
    logic             tx_full;
    logic             tx_empty;
    logic [7:0]       tx_head;
    logic [LVL_W-1:0] tx_level;
    logic             rx_push;
    logic [7:0]       rx_byte;
    logic             rx_full;
    logic             rx_empty;
    logic [7:0]       rx_head;
    logic [LVL_W-1:0] rx_level;
    logic             unused_bits;

    assign word        = bus_addr[4:2];
    assign wr_en       = bus_sel && bus_wr;
    assign rd_en       = bus_sel && !bus_wr;
    assign go          = wr_en && (word == W_CTRL) && bus_wdata[31] && !busy;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata, rx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_r    <= '0;
            txcnt_r    <= '0;
            flush_tx_q <= 1'b0;
            flush_rx_q <= 1'b0;
        end else begin
            flush_tx_q <= wr_en && (word == W_QCTL) && bus_wdata[31];
            flush_rx_q <= wr_en && (word == W_QCTL) && bus_wdata[15];
            if (wr_en && word == W_TOTAL) total_r <= bus_wdata[LEN_W-1:0];
            if (wr_en && word == W_TXCNT) txcnt_r <= bus_wdata[LEN_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            W_CTRL:  bus_rdata[31] = busy;
            W_QCTL:  begin
                bus_rdata[31] = flush_tx_q;
                bus_rdata[15] = flush_rx_q;
            end
            W_TOTAL: bus_rdata[LEN_W-1:0] = total_r;
            W_TXCNT: bus_rdata[LEN_W-1:0] = txcnt_r;
            W_RXDAT: bus_rdata[7:0] = rx_head;
            W_LEVEL: begin
                bus_rdata[LVL_W-1:0]  = tx_level;
                bus_rdata[16 +: LVL_W] = rx_level;
            end
            default: bus_rdata = '0;
        endcase
    end

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_tx_q),
        .push  (wr_en && (word == W_TXDAT)),
        .din   (bus_wdata[7:0]),
        .pop   (tx_pop),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_rx_q),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rd_en && (word == W_RXDAT)),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    spi_burst_engine #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .total_len (total_r),
        .tx_len    (txcnt_r),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .busy      (busy),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .cs_n      (spi_cs_n)
    );

    // R8: queue flush requests last exactly one cycle
    p_flush_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_tx_q || flush_rx_q) |=>
            ((!flush_tx_q || $past(wr_en && word == W_QCTL)) &&
             (!flush_rx_q || $past(wr_en && word == W_QCTL))));

    // R8: a flush leaves the queue empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_rx_q && !rx_push) |=> rx_empty);

    // R9: a full transmit queue ignores writes
    p_tx_full_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_pop && !flush_tx_q) |=> tx_full);

endmodule

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;
    localparam int DEPTH   = 64;
    localparam int TCK     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_cs_n;

    int total_checks = 0;
    int bad_checks = 0;
    int seed = 0;
    int rises = 0;
    int cs_falls = 0;
    logic [7:0] cap = '0;
    logic [7:0] mosi_bytes [128];
    time t_csf = 0, t_r1 = 0, t_r2 = 0, t_lf = 0, t_csr = 0;

    always #4 clk = ~clk;

    spi_burst_master #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(DEPTH), .LEN_W(12)) i_spi_burst_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 29 + 7 + seed * 13) & 255);
    endfunction

    function automatic logic [7:0] txpat(int i);
        return 8'((i * 11 + 3 + seed) & 255);
    endfunction

    logic [7:0] cur_pat;
    always_comb begin
        cur_pat  = pat(rises / 8);
        spi_miso = cur_pat[7 - (rises % 8)];
    end

    // serial device model: capture on rising edges, restart on chip select
    always @(posedge spi_sclk or negedge spi_cs_n) begin
        if (!spi_sclk) begin
            rises    = 0;
            cs_falls = cs_falls + 1;
            t_csf    = $time;
        end else if (!spi_cs_n) begin
            if (rises == 0) t_r1 = $time;
            if (rises == 1) t_r2 = $time;
            if ((rises % 8) == 7 && (rises / 8) < 128)
                mosi_bytes[rises / 8] = {cap[6:0], spi_mosi};
            cap   = {cap[6:0], spi_mosi};
            rises = rises + 1;
        end
    end
    always @(negedge spi_sclk) t_lf = $time;
    always @(posedge spi_cs_n) t_csr = $time;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run_burst(int t, int n, int sd, bit poke);
        logic [31:0] d;
        int k, exp_rx, falls0, guard;
        seed = sd;
        bus_write(32'h04, 32'h8000_8000);
        bus_read(32'h04, d);
        chk(d == 0, "R8", "flush bits self-clear", d, 0);
        bus_read(32'h18, d);
        chk(d == 0, "R8", "levels after flush", d, 0);
        for (int i = 0; i < n; i++) bus_write(32'h10, {24'h0, txpat(i)});
        bus_write(32'h08, t);
        bus_write(32'h0C, n);
        falls0 = cs_falls;
        bus_write(32'h00, 32'h8000_0000);
        bus_read(32'h00, d);
        chk(d[31] == (t != 0), "R2", "busy after start", d[31], t != 0);
        if (poke) bus_write(32'h00, 32'h8000_0000);
        guard = 0;
        do begin
            bus_read(32'h00, d);
            guard++;
        end while (d[31] && guard < 5000);
        chk(d[31] == 0, "R2", "busy self-clears", d[31], 0);
        chk(rises == (t == 0 ? rises : 8 * t), "R3", "rising edge count", rises, 8 * t);
        chk(cs_falls == falls0 + (t != 0), "R1", "chip-select spans", cs_falls - falls0, t != 0);
        k = (n < t) ? n : t;
        exp_rx = (t - k > DEPTH) ? DEPTH : t - k;
        bus_read(32'h18, d);
        chk(d[22:16] == 7'(exp_rx), "R4", "kept byte count", d[22:16], exp_rx);
        chk(d[6:0] == 7'(n - k), "R3", "transmit bytes left", d[6:0], n - k);
        for (int i = 0; i < t && i < 128; i++) begin
            logic [7:0] e;
            e = (i < k) ? txpat(i) : 8'h00;
            chk(mosi_bytes[i] == e, (i < k) ? "R6" : "R5", "output byte", mosi_bytes[i], e);
        end
        for (int i = 0; i < exp_rx; i++) begin
            bus_read(32'h14, d);
            chk(d[7:0] == pat(k + i), "R4", "received byte", d[7:0], pat(k + i));
        end
        bus_read(32'h14, d);
        chk(d == 0, "R9", "empty receive read", d, 0);
        if (t != 0) begin
            chk(t_r1 - t_csf == HALF * TCK, "R7", "select to first edge", t_r1 - t_csf, HALF * TCK);
            chk(t_csr - t_lf == HALF * TCK, "R7", "last edge to deselect", t_csr - t_lf, HALF * TCK);
            if (t * 8 > 1)
                chk(t_r2 - t_r1 == CLK_DIV * TCK, "R7", "SCLK period", t_r2 - t_r1, CLK_DIV * TCK);
        end
    endtask

    task automatic run_all();
        logic [31:0] d;
        #1;
        chk(spi_cs_n == 1'b1, "R1", "reset select level", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "reset clock level", spi_sclk, 0);
        rst_n = 1'b1;
        bus_read(32'h00, d);
        chk(d == 0, "R2", "reset control", d, 0);
        bus_read(32'h18, d);
        chk(d == 0, "R10", "reset levels", d, 0);
        // R9 transmit queue saturates at its depth
        for (int i = 0; i < DEPTH + 6; i++) bus_write(32'h10, i);
        bus_read(32'h18, d);
        chk(d[6:0] == 7'(DEPTH), "R9", "full transmit level", d[6:0], DEPTH);
        for (int t = 0; t <= 6; t++)
            for (int n = 0; n <= 7; n++)
                run_burst(t, n, t * 8 + n, 1'b0);
        run_burst(5, 1, 61, 1'b0);
        run_burst(13, 1, 62, 1'b0);
        run_burst(4, 4, 63, 1'b0);
        run_burst(3, 2, 64, 1'b1);
        run_burst(DEPTH + 6, 0, 65, 1'b0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        repeat (3) @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) chk(1'b0, "R2", "watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule